// File: doc/BRIEF.md
# Playback Sample Format Expander

The block turns a stream of playback bytes, as fetched from memory by a DMA engine, into 16-bit signed PCM samples. A format byte and a mode flag are captured together on a load strobe. The captured pair sets the sample rate, the channel count, the byte shift per frame and the sample encoding that the byte stream carries.

Four encodings are expanded to linear 16-bit samples:
- unsigned 8-bit;
- mu-law companded bytes;
- A-law companded bytes;
- 16-bit samples in either byte order.

The companded expansions are computed with shift-and-add logic, with no lookup table. A code that is reserved or unsupported, or a rate slot with no valid entry, raises an error flag. While the flag is up, the input side is held off and playback stops.

Both stream sides use valid/ready handshakes. Each accepted byte that completes a sample writes one output register. That register stays in place until the consumer takes it.

Top module: `pfe_expander`

## Requirements
- R1: Format bit 0 picks the rate table and bits [3:1] pick the entry in it. Table 0 holds 8000, 16000, 27420, 32000, invalid, invalid, 48000, 9000. Table 1 holds 5510, 11025, 18900, 22050, 37800, 44100, 33075, 6620. An invalid entry gives `rate_hz_o` = 0 and sets `err_o`.
- R2: Format bit 4 set gives `chans_o` = 2, and clear gives 1. `byte_shift_o` follows the encoding:
  - For the 8-bit and companded encodings, it is 1 for stereo and 0 for mono.
  - For the 16-bit encodings, it equals `chans_o`.
- R3: The encoding code is format bits [7:5] when the captured mode flag is 1. When the flag is 0, it is {0, bits[6:5]} and bit 7 is ignored.
- R4: Codes 4, 5 and 7, and an invalid rate entry, set `err_o`. While `err_o` is high, `in_ready_o` is 0 and no sample is produced.
- R5: Code 1 (mu-law) maps each byte as follows:
  - Invert the byte.
  - Take exponent e from bits [6:4] and mantissa m from bits [3:0].
  - The magnitude is ((8m+132) << e) - 132.
  - The sample is negative when bit 7 of the inverted byte is 1.
  - Examples: 0x00 gives -32124, 0x80 gives +32124, and 0x7F and 0xFF give 0.
- R6: Code 3 (A-law) maps each byte as follows:
  - XOR the byte with 0x55.
  - Take exponent e from bits [6:4] and mantissa m from bits [3:0].
  - The magnitude is 16m+8 when e = 0, and otherwise (16m+264) << (e-1).
  - The sample is positive when bit 7 of the XORed byte is 1.
  - Examples: 0x00 gives -5504, 0x80 gives +5504, and 0x2A gives -32256.
- R7: Code 0 (unsigned 8-bit) gives the sample {~b[7], b[6:0], 8'h00}.
- R8: Code 2 takes two bytes per sample, low byte first. Code 6 takes two bytes per sample, high byte first. No sample is produced after the first byte.
- R9: A load strobe discards a pending first byte of a 16-bit sample. No byte is accepted in the cycle of the load.
- R10: `sample_o` and `out_valid_o` hold while `out_valid_o` is 1 and `out_ready_i` is 0. In that state `in_ready_o` is 0.
- R11: After reset:
  - the captured format and mode are 0, which gives 8000 Hz, mono and unsigned 8-bit;
  - `out_valid_o` = 0 and `err_o` = 0.
- R12: Accepting a byte that completes a sample sets `out_valid_o` with the new sample at that same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture fmt_i and mode2_i |
| fmt_i | input | 8 | Playback format byte |
| mode2_i | input | 1 | Wide (3-bit) format code select |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input byte |
| in_ready_o | output | 1 | Input byte accepted when valid |
| out_valid_o | output | 1 | Sample valid |
| sample_o | output | 16 | Signed PCM sample |
| out_ready_i | input | 1 | Consumer takes sample |
| rate_hz_o | output | 16 | Decoded sample rate, 0 if invalid |
| chans_o | output | 2 | Channel count |
| byte_shift_o | output | 2 | Byte shift per frame |
| err_o | output | 1 | Reserved/unsupported code or invalid rate |

## Verification
The assertions check four things on every cycle:
- the stall rules on both handshakes;
- that an error holds the input off;
- that a zero rate is always flagged;
- that the shift and channel outputs stay in their legal ranges.

The bench scenarios cover what needs chosen data:
- the numeric results of each expansion;
- the rate tables;
- the way the mode flag narrows the code field;
- the byte order of 16-bit samples;
- that a reload drops a half-received sample.

// File: rtl/pfe_pkg.sv
package pfe_pkg;
  typedef enum logic [2:0] {K_U8, K_MU, K_AL, K_LE, K_BE, K_BAD} kind_e;

  function automatic logic [15:0] mu_expand(input logic [7:0] b);
    logic [7:0]  u;
    logic [15:0] mag;
    u   = ~b;
    mag = ({8'b0, 1'b1, u[3:0], 3'b100} << u[6:4]) - 16'd132;
    return u[7] ? (~mag + 16'd1) : mag;
  endfunction

  function automatic logic [15:0] a_expand(input logic [7:0] b);
    logic [7:0]  a;
    logic [15:0] mag;
    a = b ^ 8'h55;
    if (a[6:4] == 3'd0) mag = {8'b0, a[3:0], 4'b1000};
    else                mag = {7'b0, 1'b1, a[3:0], 4'b1000} << (a[6:4] - 3'd1);
    return a[7] ? mag : (~mag + 16'd1);
  endfunction
endpackage

// File: rtl/pfe_decode.sv
module pfe_decode
  import pfe_pkg::*;
#(
  parameter int RATE_W = 16
) (
  input  logic [7:0]        fmt_i,
  input  logic              mode2_i,
  output kind_e             kind_o,
  output logic [RATE_W-1:0] rate_hz_o,
  output logic [1:0]        chans_o,
  output logic [1:0]        byte_shift_o,
  output logic              err_o
);
  logic [2:0] code;
  logic       stereo;

  assign code   = mode2_i ? fmt_i[7:5] : {1'b0, fmt_i[6:5]};
  assign stereo = fmt_i[4];

  always_comb begin
    unique case ({fmt_i[0], fmt_i[3:1]})
      4'h0: rate_hz_o = RATE_W'(8000);
      4'h1: rate_hz_o = RATE_W'(16000);
      4'h2: rate_hz_o = RATE_W'(27420);
      4'h3: rate_hz_o = RATE_W'(32000);
      4'h6: rate_hz_o = RATE_W'(48000);
      4'h7: rate_hz_o = RATE_W'(9000);
      4'h8: rate_hz_o = RATE_W'(5510);
      4'h9: rate_hz_o = RATE_W'(11025);
      4'hA: rate_hz_o = RATE_W'(18900);
      4'hB: rate_hz_o = RATE_W'(22050);
      4'hC: rate_hz_o = RATE_W'(37800);
      4'hD: rate_hz_o = RATE_W'(44100);
      4'hE: rate_hz_o = RATE_W'(33075);
      4'hF: rate_hz_o = RATE_W'(6620);
      default: rate_hz_o = '0;
    endcase
  end

  always_comb begin
    unique case (code)
      3'd0:    kind_o = K_U8;
      3'd1:    kind_o = K_MU;
      3'd2:    kind_o = K_LE;
      3'd3:    kind_o = K_AL;
      3'd6:    kind_o = K_BE;
      default: kind_o = K_BAD;
    endcase
  end

  assign chans_o      = stereo ? 2'd2 : 2'd1;
  assign byte_shift_o = (kind_o == K_LE || kind_o == K_BE) ? chans_o : {1'b0, stereo};
  assign err_o        = (kind_o == K_BAD) || (rate_hz_o == '0);
endmodule

// File: rtl/pfe_byte_expand.sv
module pfe_byte_expand
  import pfe_pkg::*;
(
  input  kind_e       kind_i,
  input  logic [7:0]  byte_i,
  output logic [15:0] sample_o
);
  always_comb begin
    unique case (kind_i)
      K_MU:    sample_o = mu_expand(byte_i);
      K_AL:    sample_o = a_expand(byte_i);
      default: sample_o = {~byte_i[7], byte_i[6:0], 8'h00};
    endcase
  end
endmodule

// File: rtl/pfe_assemble.sv
module pfe_assemble
  import pfe_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        flush_i,
  input  logic        halt_i,
  input  kind_e       kind_i,
  input  logic        in_valid_i,
  input  logic [7:0]  in_data_i,
  output logic        in_ready_o,
  output logic        out_valid_o,
  output logic [15:0] sample_o,
  input  logic        out_ready_i
);
  logic        pend_q;
  logic [7:0]  hold_q;
  logic        out_valid_q;
  logic [15:0] sample_q;
  logic [15:0] narrow_s;
  logic        wide, accept, produce;

  pfe_byte_expand u_expand (.kind_i(kind_i), .byte_i(in_data_i), .sample_o(narrow_s));

  assign wide       = (kind_i == K_LE) || (kind_i == K_BE);
  assign in_ready_o = !halt_i && !flush_i && (!out_valid_q || out_ready_i);
  assign accept     = in_valid_i && in_ready_o;
  assign produce    = accept && (!wide || pend_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      hold_q <= '0;
    end else if (flush_i) begin
      pend_q <= 1'b0;
    end else if (accept && wide) begin
      pend_q <= !pend_q;
      if (!pend_q) hold_q <= in_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      sample_q    <= '0;
    end else if (produce) begin
      out_valid_q <= 1'b1;
      if (!wide)               sample_q <= narrow_s;
      else if (kind_i == K_LE) sample_q <= {in_data_i, hold_q};
      else                     sample_q <= {hold_q, in_data_i};
    end else if (out_ready_i) begin
      out_valid_q <= 1'b0;
    end
  end

  assign out_valid_o = out_valid_q;
  assign sample_o    = sample_q;
endmodule

// File: rtl/pfe_expander.sv
module pfe_expander
  import pfe_pkg::*;
#(
  parameter int RATE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [7:0]        fmt_i,
  input  logic              mode2_i,
  input  logic              in_valid_i,
  input  logic [7:0]        in_data_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [15:0]       sample_o,
  input  logic              out_ready_i,
  output logic [RATE_W-1:0] rate_hz_o,
  output logic [1:0]        chans_o,
  output logic [1:0]        byte_shift_o,
  output logic              err_o
);
  logic [7:0] fmt_q;
  logic       mode2_q;
  kind_e      kind_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fmt_q   <= '0;
      mode2_q <= 1'b0;
    end else if (load_i) begin
      fmt_q   <= fmt_i;
      mode2_q <= mode2_i;
    end
  end

  pfe_decode #(.RATE_W(RATE_W)) u_decode (
    .fmt_i(fmt_q), .mode2_i(mode2_q), .kind_o(kind_s), .rate_hz_o(rate_hz_o),
    .chans_o(chans_o), .byte_shift_o(byte_shift_o), .err_o(err_o)
  );

  pfe_assemble u_assemble (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(load_i), .halt_i(err_o), .kind_i(kind_s),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_ready_o(in_ready_o),
    .out_valid_o(out_valid_o), .sample_o(sample_o), .out_ready_i(out_ready_i)
  );
endmodule

// File: rtl/pfe_checker.sv
module pfe_checker #(
  parameter int RATE_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic [15:0]       sample_o,
  input logic              out_ready_i,
  input logic [RATE_W-1:0] rate_hz_o,
  input logic [1:0]        chans_o,
  input logic [1:0]        byte_shift_o,
  input logic              err_o
);
  a_r4_err_holds_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !in_ready_o);
  a_r1_zero_rate_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_hz_o == '0) |-> err_o);
  a_r10_output_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(sample_o)));
  a_r10_input_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);
  a_r9_no_accept_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !in_ready_o);
  a_r2_shift_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chans_o == 2'd1 || chans_o == 2'd2) && (byte_shift_o <= chans_o));
endmodule

bind pfe_expander pfe_checker #(.RATE_W(RATE_W)) u_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .in_ready_o(in_ready_o),
  .out_valid_o(out_valid_o), .sample_o(sample_o), .out_ready_i(out_ready_i),
  .rate_hz_o(rate_hz_o), .chans_o(chans_o), .byte_shift_o(byte_shift_o), .err_o(err_o)
);

// File: tb/pfe_expander_tb.sv
module pfe_expander_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [7:0]  fmt = '0;
  logic        mode2 = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, out_valid, out_ready = 1'b1, err;
  logic [15:0] sample, rate;
  logic [1:0]  chans, shift;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfe_expander dut_i (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .fmt_i(fmt), .mode2_i(mode2),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .sample_o(sample), .out_ready_i(out_ready),
    .rate_hz_o(rate), .chans_o(chans), .byte_shift_o(shift), .err_o(err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_fmt(input logic [7:0] f, input logic m);
    @(negedge clk); fmt = f; mode2 = m; load = 1'b1;
    @(negedge clk); load = 1'b0;
  endtask

  // push one byte; result visible at the returning negedge
  task automatic push(input logic [7:0] b);
    @(negedge clk); in_valid = 1'b1; in_data = b;
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic push_expect(input string req, input logic [7:0] b, input logic [15:0] e);
    push(b);
    chk(req, int'(out_valid), 1);
    chk(req, int'($signed(sample)), int'($signed(e)));
  endtask

  task automatic t_reset;
    chk("R11 rate", int'(rate), 8000);
    chk("R11 chans", int'(chans), 1);
    chk("R11 valid", int'(out_valid), 0);
    chk("R11 err", int'(err), 0);
    push_expect("R11 u8 default", 8'h80, 16'h0000);
  endtask

  task automatic t_rates;
    load_fmt(8'h0C, 1'b0); chk("R1 t0 idx6", int'(rate), 48000);
    load_fmt(8'h0D, 1'b0); chk("R1 t1 idx6", int'(rate), 33075);
    load_fmt(8'h0F, 1'b0); chk("R1 t1 idx7", int'(rate), 6620);
    load_fmt(8'h05, 1'b0); chk("R1 t1 idx2", int'(rate), 18900);
    load_fmt(8'h04, 1'b0); chk("R1 t0 idx2", int'(rate), 27420);
    load_fmt(8'h0A, 1'b0); chk("R1 invalid rate", int'(rate), 0);
    chk("R4 invalid rate err", int'(err), 1);
    chk("R4 invalid rate ready", int'(in_ready), 0);
  endtask

  task automatic t_shift;
    load_fmt(8'h10, 1'b0); chk("R2 u8 st chans", int'(chans), 2); chk("R2 u8 st shift", int'(shift), 1);
    load_fmt(8'h20, 1'b0); chk("R2 mu mono shift", int'(shift), 0);
    load_fmt(8'h50, 1'b0); chk("R2 le st shift", int'(shift), 2);
    load_fmt(8'h40, 1'b0); chk("R2 le mono shift", int'(shift), 1);
  endtask

  task automatic t_u8;
    load_fmt(8'h00, 1'b0);
    push_expect("R7 u8 0x12", 8'h12, 16'h9200);
    push_expect("R7 u8 0xFF", 8'hFF, 16'h7F00);
    push_expect("R12 u8 0x00", 8'h00, 16'h8000);
  endtask

  task automatic t_mu;
    load_fmt(8'h20, 1'b0);
    push_expect("R5 mu 0x00", 8'h00, -16'sd32124);
    push_expect("R5 mu 0x80", 8'h80, 16'sd32124);
    push_expect("R5 mu 0x7F", 8'h7F, 16'd0);
    push_expect("R5 mu 0xFF", 8'hFF, 16'd0);
    push_expect("R5 mu 0x8F", 8'h8F, 16'sd16764);
  endtask

  task automatic t_alaw;
    load_fmt(8'h60, 1'b0);
    push_expect("R6 a 0x00", 8'h00, -16'sd5504);
    push_expect("R6 a 0x80", 8'h80, 16'sd5504);
    push_expect("R6 a 0x2A", 8'h2A, -16'sd32256);
    push_expect("R6 a 0xD5", 8'hD5, 16'sd8);
  endtask

  task automatic t_wide;
    load_fmt(8'h40, 1'b0);
    push(8'h34); chk("R8 le first no sample", int'(out_valid), 0);
    push_expect("R8 le", 8'h12, 16'h1234);
    load_fmt(8'hC0, 1'b1);
    push(8'hAB); chk("R8 be first no sample", int'(out_valid), 0);
    push_expect("R8 be", 8'hCD, 16'hABCD);
  endtask

  task automatic t_mode;
    load_fmt(8'hC0, 1'b0);
    chk("R3 narrow ignores bit7 err", int'(err), 0);
    push(8'h01); push_expect("R3 narrow code2 le", 8'h02, 16'h0201);
    load_fmt(8'h80, 1'b0);
    push_expect("R3 narrow 0x80 is u8", 8'h12, 16'h9200);
    load_fmt(8'h80, 1'b1); chk("R4 code4 err", int'(err), 1);
    push(8'h55); chk("R4 no sample on err", int'(out_valid), 0);
    load_fmt(8'hA0, 1'b1); chk("R4 code5 err", int'(err), 1);
    load_fmt(8'hE0, 1'b1); chk("R4 code7 err", int'(err), 1);
  endtask

  task automatic t_reload;
    load_fmt(8'h40, 1'b0);
    push(8'h11);
    load_fmt(8'h40, 1'b0);
    push(8'h22);
    chk("R9 no sample after reload", int'(out_valid), 0);
    push_expect("R9 pending dropped", 8'h33, 16'h3322);
  endtask

  task automatic t_stall;
    load_fmt(8'h00, 1'b0);
    @(negedge clk); out_ready = 1'b0; in_valid = 1'b1; in_data = 8'h12;
    @(negedge clk); in_data = 8'h34;
    chk("R12 sample", int'(sample), 16'h9200);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10 held valid", int'(out_valid), 1);
      chk("R10 held sample", int'(sample), 16'h9200);
      chk("R10 ready low", int'(in_ready), 0);
    end
    out_ready = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    chk("R10 resumes", int'(sample), 16'hB400);
    @(negedge clk);
    chk("R10 drained", int'(out_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_rates;
    t_shift;
    t_u8;
    t_mu;
    t_alaw;
    t_wide;
    t_mode;
    t_reload;
    t_stall;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule